// File: doc/BRIEF.md
# Memory Command Queue with Early-Warning Occupancy Flags

This block is a synchronous first-in first-out store for memory commands. Each command pairs a target address with a 5-bit block length. A controller uses two copies of the block, one for read commands and one for write commands. The user side pushes a command by holding `push_en` high across a rising clock edge. The downstream command sequencer always sees the oldest stored command on `head_addr`/`head_len` and removes it by raising `pop_req`.

Occupancy is reported by four registered flags: `is_empty`, `is_full`, and two early warnings, `is_full_m1` and `is_full_m2`. The warnings rise one and two entries short of full. Because they rise early, a user pipeline that needs a cycle or two to react can stop issuing commands before any of them is lost. A three-state controller tracks the queue. The states are EMPTY (nothing stored), PARTIAL (between one and DEPTH−1 entries) and FULL (DEPTH entries). The transitions are:
- FILL_FIRST: EMPTY→PARTIAL, on an accepted push.
- FILL_LAST: PARTIAL→FULL, on a push without a pop at DEPTH−1 entries.
- DRAIN_LAST: PARTIAL→EMPTY, on a pop without a push at one entry.
- DRAIN_FIRST: FULL→PARTIAL, on an accepted pop.

All other cases hold the current state. DEPTH may be 4, 8, 16, 32 or 64, and the default is 4.

Top module: `cmd_queue`

## Requirements
- R1: While `rst_n` is low and after it is released, the queue holds no entries: `is_empty`=1 and `is_full`, `is_full_m1`, `is_full_m2` are all 0.
- R2: When `push_en` is high at a rising edge and the queue is not full, {`push_addr`,`push_len`} is stored. Entries leave in arrival order. Whenever `is_empty` is 0, `head_addr`/`head_len` show the oldest stored entry.
- R3: `is_empty` is 1 exactly when the occupancy is 0, and `is_full` is 1 exactly when the occupancy equals DEPTH.
- R4: `is_full_m1` is 1 exactly when the occupancy is at least DEPTH−1.
- R5: `is_full_m2` is 1 exactly when the occupancy is at least DEPTH−2.
- R6: All four flags are registered and change on the same rising edge that changes the occupancy.
- R7: A push while full is dropped and the stored contents stay unchanged. If a pop arrives in the same cycle, the pop is performed and the push is still dropped.
- R8: A pop while empty is ignored. A push and a pop together while empty store the pushed entry.
- R9: A push and a pop in the same cycle with occupancy between 1 and DEPTH−1 leave the occupancy unchanged and advance the head to the next entry.
- R10: The block-length field is 5 bits and the address field is ADDR_W bits (17 to 20, default 20); both fields are stored without loss, including all-ones values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_en | input | 1 | Store the command on the push buses at this edge |
| push_addr | input | ADDR_W | Address of the pushed command |
| push_len | input | 5 | Block length of the pushed command |
| pop_req | input | 1 | Remove the head command at this edge |
| head_addr | output | ADDR_W | Address of the oldest stored command |
| head_len | output | 5 | Block length of the oldest stored command |
| is_empty | output | 1 | No commands stored |
| is_full | output | 1 | DEPTH commands stored |
| is_full_m1 | output | 1 | At least DEPTH−1 commands stored |
| is_full_m2 | output | 1 | At least DEPTH−2 commands stored |

## Verification
The properties assume that `push_en` and `pop_req` are known (0 or 1) at every clock edge after reset. They also assume that the head buses are only considered meaningful while `is_empty` is low. The bench drives both controls at the falling edge with plain 0/1 values. It checks the head only against a non-empty reference model, so the stimulus never relies on head contents of an empty queue. The sweep covers every push/pop pairing at every occupancy from zero to DEPTH, which deliberately includes the dropped-push and ignored-pop cases.

// File: rtl/cmd_queue_pkg.sv
package cmd_queue_pkg;
    localparam int LEN_W = 5;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } q_state_t;
endpackage

// File: rtl/cmd_queue_ctrl.sv
module cmd_queue_ctrl
    import cmd_queue_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          wr_fire,
    output logic          rd_fire,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic          flag_empty,
    output logic          flag_full,
    output logic          flag_m1,
    output logic          flag_m2
);
    q_state_t      state_q, state_d;
    logic [CW-1:0] count_q, count_d;

    // Acceptance depends only on the registered state.
    always_comb begin
        wr_fire = push_req && (state_q != ST_FULL);
        rd_fire = pop_req  && (state_q != ST_EMPTY);
        count_d = count_q + CW'(wr_fire) - CW'(rd_fire);
    end

    // Next-state logic with the four named transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_fire) state_d = ST_PARTIAL;                // FILL_FIRST
            end
            ST_PARTIAL: begin
                if (wr_fire && !rd_fire && count_q == CW'(DEPTH - 1))
                    state_d = ST_FULL;                            // FILL_LAST
                else if (rd_fire && !wr_fire && count_q == CW'(1))
                    state_d = ST_EMPTY;                           // DRAIN_LAST
            end
            ST_FULL: begin
                if (rd_fire) state_d = ST_PARTIAL;                // DRAIN_FIRST
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Occupancy and pointers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            count_q <= count_d;
            if (wr_fire) wr_ptr <= wr_ptr + PW'(1);
            if (rd_fire) rd_ptr <= rd_ptr + PW'(1);
        end
    end

    // Registered status outputs, updated on the edge that moves the count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_empty <= 1'b1;
            flag_full  <= 1'b0;
            flag_m1    <= 1'b0;
            flag_m2    <= 1'b0;
        end else begin
            flag_empty <= (state_d == ST_EMPTY);
            flag_full  <= (state_d == ST_FULL);
            flag_m1    <= (count_d >= CW'(DEPTH - 1));
            flag_m2    <= (count_d >= CW'(DEPTH - 2));
        end
    end
endmodule

// File: rtl/cmd_queue_store.sv
module cmd_queue_store #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 25,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [PW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_idx] <= wr_word;
    end

    assign rd_word = slots[rd_idx];
endmodule

// File: rtl/cmd_queue.sv
module cmd_queue
    import cmd_queue_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 20,
    localparam int PW    = $clog2(DEPTH),
    localparam int WORD_W = ADDR_W + LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [LEN_W-1:0]  push_len,
    input  logic              pop_req,
    output logic [ADDR_W-1:0] head_addr,
    output logic [LEN_W-1:0]  head_len,
    output logic              is_empty,
    output logic              is_full,
    output logic              is_full_m1,
    output logic              is_full_m2
);
    if (DEPTH != 4 && DEPTH != 8 && DEPTH != 16 && DEPTH != 32 && DEPTH != 64) begin : g_bad_depth
        $error("cmd_queue: DEPTH must be 4, 8, 16, 32 or 64");
    end
    if (ADDR_W < 17 || ADDR_W > 20) begin : g_bad_addr
        $error("cmd_queue: ADDR_W must be 17 to 20");
    end

    logic          wr_fire, rd_fire;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [WORD_W-1:0] head_word;

    cmd_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (push_en),
        .pop_req    (pop_req),
        .wr_fire    (wr_fire),
        .rd_fire    (rd_fire),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .flag_empty (is_empty),
        .flag_full  (is_full),
        .flag_m1    (is_full_m1),
        .flag_m2    (is_full_m2)
    );

    cmd_queue_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_fire),
        .wr_idx  (wr_ptr),
        .wr_word ({push_addr, push_len}),
        .rd_idx  (rd_ptr),
        .rd_word (head_word)
    );

    assign {head_addr, head_len} = head_word;
endmodule

// File: rtl/cmd_queue_chk.sv
module cmd_queue_chk #(
    parameter int HW = 25
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_en,
    input logic          pop_req,
    input logic [HW-1:0] head,
    input logic          is_empty,
    input logic          is_full,
    input logic          is_full_m1,
    input logic          is_full_m2
);
    assert_empty_full_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_empty && is_full));

    assert_full_nests_m1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_full |-> is_full_m1);

    assert_m1_nests_m2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_full_m1 |-> is_full_m2);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_en && !pop_req) |=> (is_full && $stable(head)));

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && pop_req && !push_en) |=> is_empty);

    assert_push_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !is_full) |=> !is_empty);

    assert_pushpop_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_req && !is_empty && !is_full)
        |=> $stable({is_empty, is_full, is_full_m1, is_full_m2}));
endmodule

bind cmd_queue cmd_queue_chk #(.HW(ADDR_W + cmd_queue_pkg::LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_en    (push_en),
    .pop_req    (pop_req),
    .head       ({head_addr, head_len}),
    .is_empty   (is_empty),
    .is_full    (is_full),
    .is_full_m1 (is_full_m1),
    .is_full_m2 (is_full_m2)
);

// File: tb/cmd_queue_bench.sv
`timescale 1ns/1ps
module cmd_queue_bench;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 20;
    localparam int WW     = ADDR_W + 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_en = 1'b0;
    logic [ADDR_W-1:0] push_addr = '0;
    logic [4:0]        push_len = '0;
    logic              pop_req = 1'b0;
    logic [ADDR_W-1:0] head_addr;
    logic [4:0]        head_len;
    logic              is_empty, is_full, is_full_m1, is_full_m2;

    int tests = 0;
    int fails = 0;
    logic [WW-1:0] model [$];
    int serial = 0;

    always #4 clk = ~clk;

    cmd_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cmd_queue (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_addr(push_addr),
        .push_len(push_len), .pop_req(pop_req), .head_addr(head_addr),
        .head_len(head_len), .is_empty(is_empty), .is_full(is_full),
        .is_full_m1(is_full_m1), .is_full_m2(is_full_m2)
    );

    task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int n;
        n = model.size();
        check({tag, " R3 empty"}, WW'(is_empty), WW'(n == 0));
        check({tag, " R3 full"},  WW'(is_full),  WW'(n == DEPTH));
        check({tag, " R4 m1"},    WW'(is_full_m1), WW'(n >= DEPTH - 1));
        check({tag, " R5 m2"},    WW'(is_full_m2), WW'(n >= DEPTH - 2));
        if (n != 0) check({tag, " R2 head"}, {head_addr, head_len}, model[0]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_en = 1'b0; pop_req = 1'b0;
        @(negedge clk);
        model.delete();
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R1 after reset");
    endtask

    // One cycle: drive at falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic p, input logic q, input logic [WW-1:0] w);
        string tag;
        int n;
        n = model.size();
        if (p && q && n > 0 && n < DEPTH) tag = "R9 pushpop";
        else if (p && n == DEPTH)         tag = "R7 drop";
        else if (q && n == 0)             tag = "R8 ignore";
        else                              tag = "R6 step";
        @(negedge clk);
        push_en = p; pop_req = q;
        {push_addr, push_len} = w;
        @(posedge clk); #1;
        if (q && n > 0) void'(model.pop_front());
        if (p && n < DEPTH) model.push_back(w);
        push_en = 1'b0; pop_req = 1'b0;
        check_all(tag);
    endtask

    function automatic logic [WW-1:0] next_word();
        serial++;
        return WW'(serial * 32'h0009_E3B5);
    endfunction

    initial begin
        do_reset();
        // R10: all-ones and all-zeros words survive storage.
        step(1'b1, 1'b0, {WW{1'b1}});
        step(1'b1, 1'b0, '0);
        check("R10 len all ones", WW'(head_len), WW'(5'd31));
        check("R10 addr all ones", WW'(head_addr), WW'({ADDR_W{1'b1}}));
        step(1'b0, 1'b1, '0);
        check("R10 zero word", {head_addr, head_len}, '0);

        // Sweep every push/pop pairing at every occupancy.
        for (int occ = 0; occ <= DEPTH; occ++) begin
            for (int combo = 0; combo < 4; combo++) begin
                do_reset();
                for (int k = 0; k < occ; k++) step(1'b1, 1'b0, next_word());
                step(combo[0], combo[1], next_word());
                for (int k = 0; k <= DEPTH; k++) step(1'b0, 1'b1, '0);
            end
        end

        // Pseudo-random traffic.
        begin
            logic [15:0] lfsr;
            lfsr = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[0] | lfsr[3], lfsr[1] & ~lfsr[5] | lfsr[7] & lfsr[2], next_word());
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule